// File: doc/BRIEF.md
# Inverter Duty-Ratio Control Law with Reference Feedforward

This block computes the switching duty command of a single-phase voltage-source inverter, once per sampling period. A single-cycle strobe marks each sampling instant. At the strobe the block captures four sampled quantities: the capacitor voltage, the inductor current, the voltage reference, and the current reference made by an external voltage compensator. It also captures the run-time gain settings. It returns the voltage error to that compensator. It then runs a proportional inner current loop and adds a feedforward term taken straight from the voltage reference. Because of that term, the output follows the reference with unity gain even when the feedback gain is kept low for stability.

Duty is normalized so that 0 means the bridge drives -Vdc and full scale means +Vdc. The gain input `hinv_i` carries 1/(2·Vdc), so the voltage demand maps onto a duty around mid-scale. The result finishes a fixed three cycles after the strobe. It reaches the PWM generator only at the following strobe, which gives a one-sample update delay. Strobes must be at least four clock cycles apart.

Top module: `inv_duty_ctl`

## Requirements
- R1: While reset is low, and after it until the first strobe, `duty_o` is 2048 (mid-scale, zero average output), `sat_o` is 0, `duty_valid_o` is 0 and `v_err_o` is 0.
- R2: At a strobe edge, `v_err_o` takes the value v_ref_i − v_cap_i (17-bit signed) and holds it until the next strobe.
- R3: The duty computed from one strobe is d = 2048 + rnd12(hinv·(rnd8(kc·(i_ref − i_ind)) + rnd8(kff·v_ref))), where rnd_s(x) = floor((x + 2^(s−1)) / 2^s). The gains kc and kff are signed Q7.8 (kc = 8 is 2048, kff = 1 is 256), hinv is signed with 20 fractional bits, and the samples carry 4 fractional bits.
- R4: With kff = 0 the reference adds nothing: zero current error gives exactly 2048 for any v_ref.
- R5: A computed d below 0 becomes 0 and above 4095 becomes 4095, and in both cases the saturation flag of that sample is 1. Otherwise the flag is 0.
- R6: `duty_valid_o` is high for exactly one cycle, three clock edges after the strobe edge, and at no other time.
- R7: `duty_o` and `sat_o` change only at a strobe edge. They take the result computed from the previous strobe's samples, so the first strobe after reset applies 2048.
- R8: Gain inputs are captured at the strobe. Changing them while the computation is in flight does not alter that sample's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sampling-instant strobe, one cycle |
| v_cap_i | input | 16 | Sampled capacitor voltage, signed, 4 fractional bits |
| i_ind_i | input | 16 | Sampled inductor current, signed, 4 fractional bits |
| v_ref_i | input | 16 | Voltage reference, signed, 4 fractional bits |
| i_ref_i | input | 16 | Current reference from the voltage compensator |
| kc_i | input | 16 | Current-loop gain, signed Q7.8 |
| kff_i | input | 16 | Feedforward gain, signed Q7.8 |
| hinv_i | input | 16 | 1/(2·Vdc), signed, 20 fractional bits |
| v_err_o | output | 17 | Voltage error to the compensator |
| duty_o | output | 12 | Applied duty, 0..4095 |
| sat_o | output | 1 | Applied duty was clamped |
| duty_valid_o | output | 1 | Next duty computed |

## Verification
The hardest behaviour to reach is a gain that changes while the three-stage computation is still running. Another is telling a result that is applied at once from one that is held for a whole sample. The stimulus changes every gain in the cycle right after a strobe. It also varies the gap between strobes from four to nine cycles. A per-clock model then shows whether the value captured at the strobe was the one used. The stimulus also drives large references with large 1/(2·Vdc) values to push the sum past both clamp limits, and alternates kff between 0 and 1.

// File: rtl/inv_duty_pkg.sv
package inv_duty_pkg;
  localparam int unsigned PIPE_LAT = 3;

  typedef enum logic [1:0] {
    CLP_NONE = 2'd0,
    CLP_LOW  = 2'd1,
    CLP_HIGH = 2'd2
  } clamp_e;
endpackage

// File: rtl/rnd_mul.sv
module rnd_mul #(
  parameter int AW = 16,
  parameter int BW = 16,
  parameter int SH = 8,
  parameter int OW = AW + BW + 1 - SH
) (
  input  logic signed [AW-1:0] a_i,
  input  logic signed [BW-1:0] b_i,
  output logic signed [OW-1:0] p_o
);
  localparam int FW = AW + BW + 1;
  localparam logic signed [FW-1:0] HALF_LSB = FW'(1) <<< (SH - 1);

  logic signed [FW-1:0] ax, bx, full, rnd;

  assign ax   = {{(BW + 1){a_i[AW-1]}}, a_i};
  assign bx   = {{(AW + 1){b_i[BW-1]}}, b_i};
  assign full = ax * bx;
  assign rnd  = full + HALF_LSB;
  assign p_o  = rnd[FW-1:SH];
endmodule

// File: rtl/duty_clamp.sv
module duty_clamp
  import inv_duty_pkg::*;
#(
  parameter int IW  = 33,
  parameter int DTW = 12
) (
  input  logic signed [IW-1:0]  val_i,
  output logic        [DTW-1:0] duty_o,
  output clamp_e                kind_o
);
  localparam logic signed [IW-1:0] MAXV = (IW'(1) <<< DTW) - IW'(1);

  always_comb begin
    if (val_i < 0) begin
      duty_o = '0;
      kind_o = CLP_LOW;
    end else if (val_i > MAXV) begin
      duty_o = '1;
      kind_o = CLP_HIGH;
    end else begin
      duty_o = val_i[DTW-1:0];
      kind_o = CLP_NONE;
    end
  end
endmodule

// File: rtl/inv_duty_ctl.sv
module inv_duty_ctl
  import inv_duty_pkg::*;
#(
  parameter int DW  = 16,
  parameter int SF  = 4,
  parameter int GW  = 16,
  parameter int GF  = 8,
  parameter int HW  = 16,
  parameter int HF  = 20,
  parameter int DTW = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [DW-1:0]     v_cap_i,
  input  logic [DW-1:0]     i_ind_i,
  input  logic [DW-1:0]     v_ref_i,
  input  logic [DW-1:0]     i_ref_i,
  input  logic [GW-1:0]     kc_i,
  input  logic [GW-1:0]     kff_i,
  input  logic [HW-1:0]     hinv_i,
  output logic [DW:0]       v_err_o,
  output logic [DTW-1:0]    duty_o,
  output logic              sat_o,
  output logic              duty_valid_o
);
  localparam int EW  = DW + 1;
  localparam int OW1 = EW + GW + 1 - GF;
  localparam int OW2 = DW + GW + 1 - GF;
  localparam int UW  = OW1 + 1;
  localparam int SH  = SF + HF - DTW;
  localparam int OW3 = UW + HW + 1 - SH;
  localparam logic [DTW-1:0] MID = DTW'(1) << (DTW - 1);
  localparam logic signed [OW3:0] MID_S = (OW3 + 1)'(1) <<< (DTW - 1);

  // stage 1: capture
  logic signed [EW-1:0] err_q, verr_q;
  logic signed [DW-1:0] vref_q;
  logic signed [GW-1:0] kc_q, kff_q;
  logic signed [HW-1:0] hinv_q, hinv2_q;
  logic                 v1_q, v2_q;
  logic signed [EW-1:0] err_d, verr_d;

  assign err_d  = {i_ref_i[DW-1], i_ref_i} - {i_ind_i[DW-1], i_ind_i};
  assign verr_d = {v_ref_i[DW-1], v_ref_i} - {v_cap_i[DW-1], v_cap_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= '0;
      verr_q <= '0;
      vref_q <= '0;
      kc_q   <= '0;
      kff_q  <= '0;
      hinv_q <= '0;
      v1_q   <= 1'b0;
    end else begin
      v1_q <= sample_i;
      if (sample_i) begin
        err_q  <= err_d;
        verr_q <= verr_d;
        vref_q <= v_ref_i;
        kc_q   <= kc_i;
        kff_q  <= kff_i;
        hinv_q <= hinv_i;
      end
    end
  end

  // stage 2: gain products
  logic signed [OW1-1:0] pc_d, pc_q;
  logic signed [OW2-1:0] pf_d, pf_q;

  rnd_mul #(.AW(EW), .BW(GW), .SH(GF)) u_mul_kc (
    .a_i(err_q), .b_i(kc_q), .p_o(pc_d)
  );

  rnd_mul #(.AW(DW), .BW(GW), .SH(GF)) u_mul_kff (
    .a_i(vref_q), .b_i(kff_q), .p_o(pf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      pf_q    <= '0;
      hinv2_q <= '0;
      v2_q    <= 1'b0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        pc_q    <= pc_d;
        pf_q    <= pf_d;
        hinv2_q <= hinv_q;
      end
    end
  end

  // stage 3: scale by 1/(2Vdc), offset to mid-scale, clamp
  logic signed [UW-1:0]  usum;
  logic signed [OW3-1:0] q_d;
  logic signed [OW3:0]   dsum;
  logic [DTW-1:0]        duty_c;
  clamp_e                kind_c;

  assign usum = {{(UW - OW1){pc_q[OW1-1]}}, pc_q} + {{(UW - OW2){pf_q[OW2-1]}}, pf_q};

  rnd_mul #(.AW(UW), .BW(HW), .SH(SH)) u_mul_hinv (
    .a_i(usum), .b_i(hinv2_q), .p_o(q_d)
  );

  assign dsum = {q_d[OW3-1], q_d} + MID_S;

  duty_clamp #(.IW(OW3 + 1), .DTW(DTW)) u_clamp (
    .val_i(dsum), .duty_o(duty_c), .kind_o(kind_c)
  );

  logic [DTW-1:0] pend_q, duty_q;
  logic           pend_sat_q, sat_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= MID;
      pend_sat_q <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= v2_q;
      if (v2_q) begin
        pend_q     <= duty_c;
        pend_sat_q <= (kind_c != CLP_NONE);
      end
    end
  end

  // one-sample update delay: result is applied at the next strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= MID;
      sat_q  <= 1'b0;
    end else if (sample_i) begin
      duty_q <= pend_q;
      sat_q  <= pend_sat_q;
    end
  end

  assign v_err_o      = verr_q;
  assign duty_o       = duty_q;
  assign sat_o        = sat_q;
  assign duty_valid_o = valid_q;

  // R6
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> ##3 duty_valid_o);

  // R6
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_valid_o |-> $past(sample_i, 3));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(duty_o) && $stable(sat_o) && $stable(v_err_o));

  // R5
  sat_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> (duty_o == '0 || duty_o == '1));
endmodule

// File: tb/tb_inv_duty_ctl.sv
module tb_inv_duty_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_i = 1'b0;
  logic [15:0] v_cap_i = '0, i_ind_i = '0, v_ref_i = '0, i_ref_i = '0;
  logic [15:0] kc_i = '0, kff_i = '0, hinv_i = '0;
  logic [16:0] v_err_o;
  logic [11:0] duty_o;
  logic        sat_o, duty_valid_o;

  int compared = 0;
  int mismatched = 0;
  string req_tag = "R1";
  bit done = 1'b0;

  inv_duty_ctl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i),
    .v_cap_i(v_cap_i), .i_ind_i(i_ind_i), .v_ref_i(v_ref_i), .i_ref_i(i_ref_i),
    .kc_i(kc_i), .kff_i(kff_i), .hinv_i(hinv_i),
    .v_err_o(v_err_o), .duty_o(duty_o), .sat_o(sat_o), .duty_valid_o(duty_valid_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  function automatic longint rnd(longint x, int s);
    return (x + (longint'(1) <<< (s - 1))) >>> s;
  endfunction

  // behavioural reference model
  longint m_duty = 2048, m_pend = 2048, m_verr = 0;
  bit     m_sat = 0, m_pend_sat = 0, m_valid = 0;
  longint cyc = 0;
  longint due_q[$];
  longint val_q[$];
  bit     satq_q[$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_duty = 2048; m_pend = 2048; m_verr = 0;
      m_sat = 0; m_pend_sat = 0; m_valid = 0;
      due_q.delete(); val_q.delete(); satq_q.delete();
    end else begin
      longint old_pend;
      bit old_psat;
      old_pend = m_pend;
      old_psat = m_pend_sat;
      m_valid = 0;
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        void'(due_q.pop_front());
        m_pend = val_q.pop_front();
        m_pend_sat = satq_q.pop_front();
        m_valid = 1;
      end
      if (sample_i) begin
        longint pc, pf, d;
        m_duty = old_pend;
        m_sat = old_psat;
        m_verr = longint'($signed(v_ref_i)) - longint'($signed(v_cap_i));
        pc = rnd(longint'($signed(kc_i)) * (longint'($signed(i_ref_i)) - longint'($signed(i_ind_i))), 8);
        pf = rnd(longint'($signed(kff_i)) * longint'($signed(v_ref_i)), 8);
        d = 2048 + rnd(longint'($signed(hinv_i)) * (pc + pf), 12);
        due_q.push_back(cyc + 2);
        if (d < 0) begin val_q.push_back(0); satq_q.push_back(1); end
        else if (d > 4095) begin val_q.push_back(4095); satq_q.push_back(1); end
        else begin val_q.push_back(d); satq_q.push_back(0); end
      end
      cyc++;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk({req_tag, " R3 R7"}, "duty_o", longint'(duty_o), m_duty);
      chk({req_tag, " R5"}, "sat_o", longint'(sat_o), longint'(m_sat));
      chk("R6", "duty_valid_o", longint'(duty_valid_o), longint'(m_valid));
      chk("R2", "v_err_o", longint'($signed(v_err_o)), m_verr);
    end
  end

  task automatic strobe(int vc, int ii, int vr, int ir, int kc, int kff, int hinv, int gap);
    @(negedge clk_i);
    v_cap_i = 16'(vc); i_ind_i = 16'(ii); v_ref_i = 16'(vr); i_ref_i = 16'(ir);
    kc_i = 16'(kc); kff_i = 16'(kff); hinv_i = 16'(hinv);
    sample_i = 1'b1;
    @(negedge clk_i);
    sample_i = 1'b0;
    repeat (gap - 1) @(negedge clk_i);
  endtask

  int unsigned seed = 32'h1234_5678;
  function automatic int unsigned lcg();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state while held in reset
    chk("R1", "duty_o in reset", longint'(duty_o), 2048);
    chk("R1", "sat_o in reset", longint'(sat_o), 0);
    chk("R1", "duty_valid_o in reset", longint'(duty_valid_o), 0);
    chk("R1", "v_err_o in reset", longint'(v_err_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R7: first strobe applies mid-scale; R3 basic
    req_tag = "R7";
    strobe(960, 40, 1000, 80, 2048, 256, 1311, 6);
    req_tag = "R3";
    strobe(-500, -30, -480, 60, 2048, 256, 1311, 6);
    strobe(100, 0, 100, 0, 1024, 256, 2622, 4);
    // R4: feedforward disabled
    req_tag = "R4";
    strobe(0, 50, 20000, 50, 2048, 0, 4000, 5);
    strobe(0, -70, -20000, -70, 3000, 0, 4000, 5);
    // R5: clamp high and low
    req_tag = "R5";
    strobe(0, 0, 30000, 0, 2048, 256, 30000, 5);
    strobe(0, 0, -30000, 0, 2048, 256, 30000, 5);
    strobe(0, 0, 10, 0, 0, 256, 100, 5);
    // R8: gains changed right after the strobe
    req_tag = "R8";
    @(negedge clk_i);
    v_cap_i = 16'(50); i_ind_i = 16'(10); v_ref_i = 16'(800); i_ref_i = 16'(90);
    kc_i = 16'(2048); kff_i = 16'(256); hinv_i = 16'(1311);
    sample_i = 1'b1;
    @(negedge clk_i);
    sample_i = 1'b0;
    kc_i = 16'(7000); kff_i = 16'(0); hinv_i = 16'(9000);
    v_ref_i = 16'(-3000); i_ref_i = 16'(-900);
    repeat (6) @(negedge clk_i);
    strobe(0, 0, 0, 0, 2048, 256, 1311, 5);
    // mixed patterns, varied strobe spacing
    req_tag = "R3";
    for (int n = 0; n < 60; n++) begin
      int sc;
      sc = (n % 2 == 0) ? 2000 : 32767;
      strobe(int'($signed(16'(lcg()))) % sc, int'($signed(16'(lcg()))) % sc,
             int'($signed(16'(lcg()))) % sc, int'($signed(16'(lcg()))) % sc,
             int'(lcg() % 4096), (n % 3 == 0) ? 0 : 256,
             int'(lcg() % 5000), 4 + int'(lcg() % 6));
    end
    strobe(0, 0, 0, 0, 2048, 256, 1311, 6);
    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule